// File: doc/BRIEF.md
# Four-Channel Programmable Interval Timer

This block holds four independent 32-bit down-counters behind a small register bus made of an address, a write strobe, write data and registered read data. Each channel has its own 64-byte register window and its own interrupt line. A channel loaded with a start value counts down by one on every clock while it is enabled. When it reaches zero it raises its pending flag. In continuous mode it then starts again from its load value. In single mode it stays at zero and turns itself off.

Software acknowledges an interrupt through a per-channel clear register. Clearing is a short handshake rather than a single write. After a clear request, a busy flag stays up for four cycles, and the pending flag drops in the same cycle that busy drops. While busy is up, further clear requests are discarded, so software polls the busy flag before it writes a clear. Every interrupt line is gated by a per-channel mask bit. A status word, which reads the same from every window, collects the pending flags of all channels.

Top module: `quad_interval_timer`

## Requirements
- R1: After reset every register reads 0, every interrupt line is low and all channels are stopped.
- R2: Channel n occupies the byte addresses 0x40*n to 0x40*n+0x3F, decoded by address bits [7:6] for the channel and [5:0] for the offset. Within a window the offsets are:
  - 0x00: status
  - 0x04: mode, bit 0
  - 0x08: load value, 32 bits
  - 0x10: enable, bit 0
  - 0x14: reload strobe, reads 0
  - 0x18: current count
  - 0x20: clear/busy
  - 0x24: mask, bit 0
  
  Any other offset reads 0.
- R3: The count register and the status register are read-only, and writes to them have no effect.
- R4: An enabled channel decrements its count by one per clock. When it is enabled with a count of 0, it sets its pending flag. In continuous mode (mode bit 0 = 0) it also reloads from the load value, so the period is load+1 cycles.
- R5: In single mode (mode bit 0 = 1) a channel that expires keeps its count at 0, and its enable bit reads 0 from then on.
- R6: Any write to the reload offset copies the load value into the count, whatever the data written.
- R7: While the enable bit is 0 the count holds its value.
- R8: Each interrupt line equals that channel's pending flag ANDed with the inverse of its mask bit, delayed by one register stage.
- R9: The clear register reads {busy in bit 1, pending in bit 0}. Writing 1 to bit 0 while busy is 0 raises busy for exactly four cycles, and the pending flag drops in the cycle busy drops. Writing 0 to bit 0 does nothing.
- R10: A clear write made while busy is 1 is ignored and does not lengthen the busy period.
- R11: If a channel expires in the same cycle that its clear completes, its pending flag stays 1.
- R12: The status word holds the pending flag of channel n in bit n and reads the same from every window.
- R13: A load value of 0xFFFFFFFF is held in full and counts down without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address: channel in [7:6], offset in [5:0] |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address of the previous cycle |
| irq_o | output | 4 | Per-channel interrupt lines, active high |

## Verification
The bench aims at the timing of the clear handshake. It reads the clear register cycle by cycle, and a design that shortened or lengthened busy, or let a second clear restart the busy period, would show busy in the wrong read. It lines up an expiry with the last busy cycle, where a design that let the clear win would show pending dropping to 0. It also checks that a single-run channel turns itself off and that a continuous channel takes load+1 cycles per period; an off-by-one there would move the interrupt by a cycle. Writes aimed at read-only registers, and reload writes carrying data 0, are also checked, because a loose decoder would corrupt the count or ignore the strobe.

// File: rtl/qit_pkg.sv
`timescale 1ns/1ps
package qit_pkg;
  localparam int WIN_W = 6;

  localparam logic [WIN_W-1:0] OFS_STATUS = 6'h00;
  localparam logic [WIN_W-1:0] OFS_MODE   = 6'h04;
  localparam logic [WIN_W-1:0] OFS_LOAD   = 6'h08;
  localparam logic [WIN_W-1:0] OFS_EN     = 6'h10;
  localparam logic [WIN_W-1:0] OFS_RELOAD = 6'h14;
  localparam logic [WIN_W-1:0] OFS_COUNT  = 6'h18;
  localparam logic [WIN_W-1:0] OFS_CLR    = 6'h20;
  localparam logic [WIN_W-1:0] OFS_MASK   = 6'h24;

  typedef enum logic [3:0] {
    RK_NONE, RK_STATUS, RK_MODE, RK_LOAD, RK_EN,
    RK_RELOAD, RK_COUNT, RK_CLR, RK_MASK
  } reg_kind_e;
endpackage

// File: rtl/qit_decode.sv
`timescale 1ns/1ps
module qit_decode
  import qit_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + WIN_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CH_W-1:0]   ch_idx,
  output logic [NUM_CH-1:0] ch_hit,
  output reg_kind_e         kind
);
  logic [WIN_W-1:0] ofs;

  assign ch_idx = addr[ADDR_W-1:WIN_W];
  assign ofs    = addr[WIN_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
    assign ch_hit[g] = (ch_idx == CH_W'(g));
  end

  always_comb begin
    case (ofs)
      OFS_STATUS: kind = RK_STATUS;
      OFS_MODE:   kind = RK_MODE;
      OFS_LOAD:   kind = RK_LOAD;
      OFS_EN:     kind = RK_EN;
      OFS_RELOAD: kind = RK_RELOAD;
      OFS_COUNT:  kind = RK_COUNT;
      OFS_CLR:    kind = RK_CLR;
      OFS_MASK:   kind = RK_MASK;
      default:    kind = RK_NONE;
    endcase
  end
endmodule

// File: rtl/qit_channel.sv
`timescale 1ns/1ps
module qit_channel #(
  parameter int CNT_W   = 32,
  parameter int CLR_CYC = 4,
  localparam int BC_W   = $clog2(CLR_CYC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] wdata,
  input  logic             wr_mode,
  input  logic             wr_load,
  input  logic             wr_en,
  input  logic             wr_reload,
  input  logic             wr_clr,
  input  logic             wr_mask,
  output logic             mode_q,
  output logic [CNT_W-1:0] load_q,
  output logic             en_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             pend_q,
  output logic             busy_q,
  output logic             mask_q,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [BC_W-1:0]  BC_INIT = BC_W'(CLR_CYC - 1);

  logic [BC_W-1:0] bc_q;
  logic            clr_go;
  logic            clr_done;

  assign expire_o = en_q && (cnt_q == '0);
  assign clr_go   = wr_clr && wdata[0] && !busy_q;
  assign clr_done = busy_q && (bc_q == '0);

  // plain configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      load_q <= '0;
      mask_q <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wdata[0];
      if (wr_load) load_q <= wdata;
      if (wr_mask) mask_q <= wdata[0];
    end
  end

  // enable: software write wins over self-stop
  always_ff @(posedge clk) begin
    if (rst)                    en_q <= 1'b0;
    else if (wr_en)             en_q <= wdata[0];
    else if (expire_o && mode_q) en_q <= 1'b0;
  end

  // down counter
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_reload) begin
      cnt_q <= load_q;
    end else if (en_q) begin
      if (cnt_q == '0) begin
        if (!mode_q) cnt_q <= load_q;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  // clear handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      bc_q   <= '0;
    end else if (clr_go) begin
      busy_q <= 1'b1;
      bc_q   <= BC_INIT;
    end else if (busy_q) begin
      if (bc_q == '0) busy_q <= 1'b0;
      else            bc_q   <= bc_q - 1'b1;
    end
  end

  // pending: a new expiry outranks the clear completing
  always_ff @(posedge clk) begin
    if (rst)           pend_q <= 1'b0;
    else if (expire_o) pend_q <= 1'b1;
    else if (clr_done) pend_q <= 1'b0;
  end
endmodule

// File: rtl/quad_interval_timer.sv
`timescale 1ns/1ps
module quad_interval_timer
  import qit_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int DATA_W  = 32,
  parameter int CLR_CYC = 4,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + WIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq_o
);
  logic [CH_W-1:0]   ch_idx;
  logic [NUM_CH-1:0] ch_hit;
  reg_kind_e         kind;

  logic [NUM_CH-1:0] mode_vec, en_vec, pend_vec, busy_vec, mask_vec, expire_vec;
  logic [DATA_W-1:0] load_arr [NUM_CH];
  logic [DATA_W-1:0] cnt_arr  [NUM_CH];

  qit_decode #(.NUM_CH(NUM_CH)) u_dec (
    .addr   (bus_addr),
    .ch_idx (ch_idx),
    .ch_hit (ch_hit),
    .kind   (kind)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic wsel;
    assign wsel = bus_we && ch_hit[g];

    qit_channel #(.CNT_W(DATA_W), .CLR_CYC(CLR_CYC)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .wdata     (bus_wdata),
      .wr_mode   (wsel && kind == RK_MODE),
      .wr_load   (wsel && kind == RK_LOAD),
      .wr_en     (wsel && kind == RK_EN),
      .wr_reload (wsel && kind == RK_RELOAD),
      .wr_clr    (wsel && kind == RK_CLR),
      .wr_mask   (wsel && kind == RK_MASK),
      .mode_q    (mode_vec[g]),
      .load_q    (load_arr[g]),
      .en_q      (en_vec[g]),
      .cnt_q     (cnt_arr[g]),
      .pend_q    (pend_vec[g]),
      .busy_q    (busy_vec[g]),
      .mask_q    (mask_vec[g]),
      .expire_o  (expire_vec[g])
    );
  end

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    case (kind)
      RK_STATUS: rd_next = {{(DATA_W-NUM_CH){1'b0}}, pend_vec};
      RK_MODE:   rd_next = {{(DATA_W-1){1'b0}}, mode_vec[ch_idx]};
      RK_LOAD:   rd_next = load_arr[ch_idx];
      RK_EN:     rd_next = {{(DATA_W-1){1'b0}}, en_vec[ch_idx]};
      RK_COUNT:  rd_next = cnt_arr[ch_idx];
      RK_CLR:    rd_next = {{(DATA_W-2){1'b0}}, busy_vec[ch_idx], pend_vec[ch_idx]};
      RK_MASK:   rd_next = {{(DATA_W-1){1'b0}}, mask_vec[ch_idx]};
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= '0;
    end else begin
      bus_rdata <= rd_next;
      irq_o     <= pend_vec & ~mask_vec;
    end
  end
endmodule

// File: rtl/qit_checker.sv
`timescale 1ns/1ps
module qit_checker #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] irq_o,
  input logic [NUM_CH-1:0] pend_vec,
  input logic [NUM_CH-1:0] busy_vec,
  input logic [NUM_CH-1:0] mask_vec,
  input logic [NUM_CH-1:0] expire_vec
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    assert_expire_pends_R4: assert property (@(posedge clk) disable iff (rst)
      expire_vec[g] |=> pend_vec[g]);

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
      irq_o[g] == $past(pend_vec[g] && !mask_vec[g]));

    assert_busy_four_R9: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_vec[g]) |=> busy_vec[g] ##1 busy_vec[g] ##1 busy_vec[g] ##1 !busy_vec[g]);

    // R9 and R11: pending after the clear ends equals whether an expiry landed then
    assert_clear_end_R11: assert property (@(posedge clk) disable iff (rst)
      $fell(busy_vec[g]) |-> pend_vec[g] == $past(expire_vec[g]));
  end
endmodule

bind quad_interval_timer qit_checker #(.NUM_CH(NUM_CH)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .irq_o      (irq_o),
  .pend_vec   (pend_vec),
  .busy_vec   (busy_vec),
  .mask_vec   (mask_vec),
  .expire_vec (expire_vec)
);

// File: tb/quad_interval_timer_tb_top.sv
`timescale 1ns/1ps
module quad_interval_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  quad_interval_timer dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;   // write data or expected read value
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h08, 32'h0000_1234, 4'd2},
    '{1'b0, 8'h08, 32'h0000_1234, 4'd2},  // R2 load read-back
    '{1'b1, 8'h44, 32'h0000_0001, 4'd2},
    '{1'b0, 8'h44, 32'h0000_0001, 4'd2},  // R2 mode ch1
    '{1'b0, 8'h04, 32'h0000_0000, 4'd2},  // R2 ch0 mode untouched
    '{1'b1, 8'hC8, 32'hFFFF_FFFF, 4'd13},
    '{1'b0, 8'hC8, 32'hFFFF_FFFF, 4'd13}, // R13 full-width load
    '{1'b1, 8'h98, 32'h0000_ABCD, 4'd3},
    '{1'b0, 8'h98, 32'h0000_0000, 4'd3},  // R3 count write ignored
    '{1'b1, 8'h00, 32'h0000_000F, 4'd3},
    '{1'b0, 8'h00, 32'h0000_0000, 4'd3},  // R3 status write ignored
    '{1'b1, 8'h14, 32'h0000_0000, 4'd6},
    '{1'b0, 8'h18, 32'h0000_1234, 4'd6},  // R6 reload with data 0
    '{1'b1, 8'hD4, 32'h0000_0001, 4'd6},
    '{1'b0, 8'hD8, 32'hFFFF_FFFF, 4'd6},  // R6 reload with data 1
    '{1'b0, 8'h14, 32'h0000_0000, 4'd2},  // R2 reload offset reads 0
    '{1'b1, 8'hA4, 32'h0000_0001, 4'd8},
    '{1'b0, 8'hA4, 32'h0000_0001, 4'd8},  // R8 mask read-back
    '{1'b1, 8'hA4, 32'h0000_0000, 4'd8},
    '{1'b0, 8'h0C, 32'h0000_0000, 4'd2},  // R2 unmapped offset
    '{1'b1, 8'h20, 32'h0000_0000, 4'd9},
    '{1'b0, 8'h20, 32'h0000_0000, 4'd9}   // R9 clear with 0 does nothing
  };

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk); @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; bus_we = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    logic [31:0] v, v2, prev;
    int n;
    bit ok;
    do_reset();

    // R1 reset state
    chk("R1 irq", {28'd0, irq_o}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    bus_rd(8'h08, v); chk("R1 load", v, 32'd0);
    bus_rd(8'h50, v); chk("R1 enable", v, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_wr(VECS[i].addr, VECS[i].data);
      else begin
        bus_rd(VECS[i].addr, v);
        checks++;
        if (v !== VECS[i].data) begin
          failures++;
          $display("FAIL R%0d vector %0d actual=0x%08h expected=0x%08h",
                   VECS[i].req, i, v, VECS[i].data);
        end
      end
    end

    // R4 continuous: load 4, interrupt seen load+2 samples after enable
    bus_wr(8'h08, 32'd4); bus_wr(8'h04, 32'd0); bus_wr(8'h14, 32'd0);
    bus_wr(8'h10, 32'd1);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); n++;
      if (irq_o[0]) break;
    end
    chk("R4 irq latency", n, 32'd6);
    ok = 1'b1;
    bus_rd(8'h18, prev);
    for (int k = 0; k < 12; k++) begin
      bus_rd(8'h18, v);
      if (v != ((prev == 0) ? 32'd4 : prev - 1)) ok = 1'b0;
      prev = v;
    end
    chk("R4 reload sequence", {31'd0, ok}, 32'd1);

    // R8 mask gating
    bus_wr(8'h24, 32'd1); @(negedge clk);
    chk("R8 masked", {31'd0, irq_o[0]}, 32'd0);
    bus_wr(8'h24, 32'd0); @(negedge clk);
    chk("R8 unmasked", {31'd0, irq_o[0]}, 32'd1);

    // R5 single run on ch1
    bus_wr(8'h48, 32'd2); bus_wr(8'h54, 32'd0); bus_wr(8'h50, 32'd1);
    repeat (8) @(negedge clk);
    bus_rd(8'h50, v); chk("R5 enable self-cleared", v, 32'd0);
    bus_rd(8'h58, v); chk("R5 count stays 0", v, 32'd0);
    bus_rd(8'h60, v); chk("R5 pending", v, 32'd1);

    // R7 disable freezes the count on ch2
    bus_wr(8'h88, 32'd100); bus_wr(8'h94, 32'd0); bus_wr(8'h90, 32'd1);
    repeat (5) @(negedge clk);
    bus_wr(8'h90, 32'd0);
    bus_rd(8'h98, v);
    repeat (10) @(negedge clk);
    bus_rd(8'h98, v2);
    chk("R7 frozen", v2, v);
    chk("R7 in range", {31'd0, (v < 100 && v > 80)}, 32'd1);

    // R9 / R10 clear handshake on ch1
    bus_wr(8'h60, 32'd0);
    bus_rd(8'h60, v); chk("R9 clear with 0", v, 32'd1);
    bus_wr(8'h60, 32'd1);
    bus_rd(8'h60, v); chk("R9 busy first", v, 32'd3);
    bus_wr(8'h60, 32'd1);   // R10 ignored while busy
    bus_rd(8'h60, v); chk("R10 still busy", v, 32'd3);
    bus_rd(8'h60, v); chk("R9 last busy", v, 32'd3);
    bus_rd(8'h60, v); chk("R10 busy ends on time", v, 32'd0);
    @(negedge clk);
    chk("R9 irq dropped", {31'd0, irq_o[1]}, 32'd0);

    // R11 expiry coinciding with clear completion on ch3
    bus_wr(8'hC8, 32'd0); bus_wr(8'hD4, 32'd0);
    bus_wr(8'hE0, 32'd1); bus_wr(8'hD0, 32'd1);
    bus_rd(8'hE0, v); chk("R11 busy only", v, 32'd2);
    bus_rd(8'hE0, v); chk("R11 busy+pend", v, 32'd3);
    bus_rd(8'hE0, v); chk("R11 busy+pend late", v, 32'd3);
    bus_rd(8'hE0, v); chk("R11 pend kept", v, 32'd1);
    bus_wr(8'hD0, 32'd0);

    // R12 shared status from a foreign window
    bus_rd(8'h80, v); chk("R12 status", v, 32'h9);

    // R13 longest period counts down
    bus_wr(8'h88, 32'hFFFF_FFFF); bus_wr(8'h94, 32'd0); bus_wr(8'h90, 32'd1);
    repeat (10) @(negedge clk);
    bus_rd(8'h98, v);
    chk("R13 count range", {31'd0, (v < 32'hFFFF_FFFF && v > 32'hFFFF_FF00)}, 32'd1);
    bus_rd(8'hC0, v); chk("R13 no pend ch2", v, 32'h9);

    // R1 reset again clears everything
    do_reset();
    chk("R1 irq after reset", {28'd0, irq_o}, 32'd0);
    bus_rd(8'h00, v); chk("R1 status after reset", v, 32'd0);
    bus_rd(8'h88, v); chk("R1 load after reset", v, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule